// File: doc/BRIEF.md
# Dual-Mode Configurable Logic Cell

This block models one programmable cell of a logic fabric. It holds a lookup table and one flip-flop. A parallel configuration word sets the cell's function. In normal mode the full table acts as one function of four data inputs. In arithmetic mode the table is cut into two equal halves. Each half is indexed by the carry input and the two low data inputs. The lower half gives the sum and the upper half gives the carry that leaves the cell. Chaining cells through their carry pins builds adders, counters, accumulators and comparators.

The flip-flop captures the table result. In arithmetic mode it can capture the register-chain input instead, so stored data can shift from one cell to the next without passing through the table. Three controls act on the flip-flop: an asynchronous clear, a synchronous clear and a synchronous load of a supplied bit. These controls are shared by a cluster of cells, so each cell holds its own enable bit for each of them. The cell output is either the combinational result or the stored bit.

The configuration word is written while `cfg_we` is high on a rising edge. It governs the cell from the next cycle onward. The cell has no streaming data path, so every pin is a plain level signal with no handshake.

Top module: `dual_mode_cell`

## Requirements
- R1: A reset (`rst_n` low) clears the stored configuration and the flip-flop, so all outputs read 0. A word on `cfg_data` is captured on a rising edge while `cfg_we` is high and takes effect after that edge. Word layout: table mask in bits 15:0, mode in bit 16 (0 normal, 1 arithmetic), output select in bit 17 (1 registered), arithmetic register source in bit 18 (1 chain input), asynchronous-clear enable in bit 19, synchronous-clear enable in bit 20, load enable in bit 21.
- R2: In normal mode `comb_out` equals mask bit number `lut_in`, read as an unsigned 4-bit index, and `carry_out` is 0. `carry_in` has no effect.
- R3: In arithmetic mode, let j = {carry_in, lut_in[1], lut_in[0]}. Then `comb_out` equals mask bit j and `carry_out` equals mask bit 8+j. `lut_in[3:2]` have no effect. With mask 16'hE896 the cell is a full adder.
- R4: When the asynchronous-clear enable is set, a high `aclr` forces the flip-flop to 0 at once, without waiting for a clock edge. When the enable is clear, `aclr` is ignored.
- R5: When the synchronous-clear enable is set, a high `sclr` at a rising edge makes the flip-flop 0. When the enable is clear, `sclr` is ignored.
- R6: When the load enable is set, a high `load` at a rising edge stores `load_val`. When the enable is clear, `load` is ignored.
- R7: With no active control, the flip-flop takes the table result at each rising edge. The one exception is arithmetic mode with register source 1, where it takes `chain_in`. `chain_out` always shows the flip-flop.
- R8: `cell_out` equals `comb_out` when the output select is 0 and the flip-flop when it is 1.
- R9: Priority among enabled controls is asynchronous clear, then synchronous clear, then load, then normal data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 22 | Configuration word |
| lut_in | input | 4 | Data inputs to the table |
| carry_in | input | 1 | Carry from the previous cell |
| chain_in | input | 1 | Register-chain input from the previous cell |
| aclr | input | 1 | Shared asynchronous clear |
| sclr | input | 1 | Shared synchronous clear |
| load | input | 1 | Shared synchronous load |
| load_val | input | 1 | Bit stored on load |
| comb_out | output | 1 | Table result (normal) or sum (arithmetic) |
| cell_out | output | 1 | Selected cell output |
| carry_out | output | 1 | Carry to the next cell |
| chain_out | output | 1 | Flip-flop value, register-chain output |

## Verification
The clocked properties assume that `aclr` never changes at a rising clock edge. They also assume that every other input is steady around that edge, so the values sampled at the edge are the ones the flip-flop saw. The bench changes every input only on falling edges, including the pulses of `aclr`, `rst_n` and `cfg_we`. This keeps both the assertions and the bench's reference model free of races at the active edge. Configuration words are changed only through the write strobe, so the mode that the assertions read is always the mode that is stored.

// File: rtl/cell_pkg.sv
package cell_pkg;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_ARITH  = 1'b1
  } cell_mode_e;

  // Control part of the configuration word; sits directly above the mask.
  typedef struct packed {
    logic       load_en;
    logic       sclr_en;
    logic       aclr_en;
    logic       reg_src;   // arithmetic mode: 1 = chain input feeds the flip-flop
    logic       out_reg;   // 1 = cell output is the flip-flop
    cell_mode_e mode;
  } cell_ctrl_t;

  localparam int CTRL_W = $bits(cell_ctrl_t);

endpackage

// File: rtl/cell_cfg_store.sv
module cell_cfg_store #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  dout <= '0;
    else if (we) dout <= din;
  end

endmodule

// File: rtl/cell_lut.sv
module cell_lut
  import cell_pkg::*;
#(
  parameter int K = 4   // table inputs; arithmetic halves use K-1 (needs K >= 3)
) (
  input  logic [(1<<K)-1:0] mask,
  input  cell_mode_e        mode,
  input  logic [K-1:0]      din,
  input  logic              cin,
  output logic              f,
  output logic              cout
);

  localparam int SIZE = 1 << K;
  localparam int HALF = SIZE / 2;

  logic [HALF-1:0] sum_tab;
  logic [HALF-1:0] car_tab;
  logic [K-2:0]    hidx;
  logic            f_norm;

  assign sum_tab = mask[HALF-1:0];
  assign car_tab = mask[SIZE-1:HALF];
  assign hidx    = {cin, din[K-3:0]};
  assign f_norm  = mask[din];

  always_comb begin
    if (mode == MODE_ARITH) begin
      f    = sum_tab[hidx];
      cout = car_tab[hidx];
    end else begin
      f    = f_norm;
      cout = 1'b0;
    end
  end

endmodule

// File: rtl/cell_reg.sv
module cell_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic aclr,
  input  logic aclr_en,
  input  logic sclr,
  input  logic sclr_en,
  input  logic load,
  input  logic load_en,
  input  logic load_val,
  input  logic d,
  output logic q
);

  logic clr_async;
  logic clr_sync;
  logic do_load;

  assign clr_async = aclr & aclr_en;
  assign clr_sync  = sclr & sclr_en;
  assign do_load   = load & load_en;

  always_ff @(posedge clk or negedge rst_n or posedge clr_async) begin
    if (!rst_n)         q <= 1'b0;
    else if (clr_async) q <= 1'b0;
    else if (clr_sync)  q <= 1'b0;
    else if (do_load)   q <= load_val;
    else                q <= d;
  end

  AST_ACLR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (aclr && aclr_en) |-> (q == 1'b0)); // R4

  AST_SCLR_WINS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sclr && sclr_en && !(aclr && aclr_en)) |=> (q == 1'b0)); // R5

  AST_LOAD_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_en && !(sclr && sclr_en) && !(aclr && aclr_en))
      |=> ((q == $past(load_val)) || (aclr && aclr_en))); // R6

endmodule

// File: rtl/dual_mode_cell.sv
module dual_mode_cell
  import cell_pkg::*;
#(
  parameter  int LUT_K = 4,
  localparam int CFG_W = (1 << LUT_K) + cell_pkg::CTRL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic [LUT_K-1:0] lut_in,
  input  logic             carry_in,
  input  logic             chain_in,
  input  logic             aclr,
  input  logic             sclr,
  input  logic             load,
  input  logic             load_val,
  output logic             comb_out,
  output logic             cell_out,
  output logic             carry_out,
  output logic             chain_out
);

  localparam int MASK_W = 1 << LUT_K;

  logic [CFG_W-1:0]  cfg_q;
  logic [MASK_W-1:0] mask;
  cell_ctrl_t        ctrl;
  logic              lut_f;
  logic              lut_c;
  logic              reg_d;
  logic              reg_q;

  cell_cfg_store #(.W(CFG_W)) u_cfg (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (cfg_we),
    .din  (cfg_data),
    .dout (cfg_q)
  );

  assign mask = cfg_q[MASK_W-1:0];
  assign ctrl = cell_ctrl_t'(cfg_q[CFG_W-1:MASK_W]);

  cell_lut #(.K(LUT_K)) u_lut (
    .mask(mask),
    .mode(ctrl.mode),
    .din (lut_in),
    .cin (carry_in),
    .f   (lut_f),
    .cout(lut_c)
  );

  assign reg_d = (ctrl.mode == MODE_ARITH && ctrl.reg_src) ? chain_in : lut_f;

  cell_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .aclr    (aclr),
    .aclr_en (ctrl.aclr_en),
    .sclr    (sclr),
    .sclr_en (ctrl.sclr_en),
    .load    (load),
    .load_en (ctrl.load_en),
    .load_val(load_val),
    .d       (reg_d),
    .q       (reg_q)
  );

  assign comb_out  = lut_f;
  assign carry_out = lut_c;
  assign chain_out = reg_q;
  assign cell_out  = ctrl.out_reg ? reg_q : lut_f;

  AST_NORMAL_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == MODE_NORMAL) |-> !carry_out); // R2

  AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == MODE_ARITH && ctrl.reg_src && !cfg_we &&
     !(aclr && ctrl.aclr_en) && !(sclr && ctrl.sclr_en) && !(load && ctrl.load_en))
      |=> ((chain_out == $past(chain_in)) || (aclr && ctrl.aclr_en))); // R7

  AST_CFG_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q == $past(cfg_data))); // R1

endmodule

// File: tb/sim_dual_mode_cell.sv
module sim_dual_mode_cell;
  localparam int K  = 4;
  localparam int CW = 22;
  localparam int B_MODE = 16, B_OSEL = 17, B_SRC = 18, B_AEN = 19, B_SEN = 20, B_LEN = 21;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_data = '0;
  logic [K-1:0]  lin = '0;
  logic cin = 0, chin = 0, aclr = 0, sclr = 0, ld = 0, lv = 0;
  logic comb_out, cell_out, carry_out, chain_out;

  dual_mode_cell #(.LUT_K(K)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .lut_in(lin), .carry_in(cin), .chain_in(chin), .aclr(aclr), .sclr(sclr),
    .load(ld), .load_val(lv), .comb_out(comb_out), .cell_out(cell_out),
    .carry_out(carry_out), .chain_out(chain_out)
  );

  int checks = 0;
  int fails  = 0;
  logic [CW-1:0] mcfg = '0;
  logic          mq = 1'b0;

  function automatic logic m_comb();
    int j;
    if (mcfg[B_MODE]) begin
      j = cin * 4 + lin[1] * 2 + lin[0];
      return mcfg[j];
    end
    return mcfg[int'(lin)];
  endfunction

  function automatic logic m_cout();
    int j;
    if (!mcfg[B_MODE]) return 1'b0;
    j = cin * 4 + lin[1] * 2 + lin[0];
    return mcfg[8 + j];
  endfunction

  function automatic logic [CW-1:0] mk(input logic [15:0] m, input logic mode,
      input logic osel, input logic src, input logic aen, input logic sen, input logic len);
    logic [CW-1:0] w;
    w = '0;
    w[15:0] = m;
    w[B_MODE] = mode; w[B_OSEL] = osel; w[B_SRC] = src;
    w[B_AEN] = aen; w[B_SEN] = sen; w[B_LEN] = len;
    return w;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    if (aclr && mcfg[B_AEN]) mq = 1'b0;
    chk(tag, "comb_out", comb_out, m_comb());
    chk(tag, "carry_out", carry_out, m_cout());
    chk(tag, "chain_out", chain_out, mq);
    chk(tag, "cell_out", cell_out, mcfg[B_OSEL] ? mq : m_comb());
  endtask

  // Inputs were set just after a falling edge; check, clock, update model, return at next falling edge.
  task automatic cyc(input string tag);
    logic nq;
    #1 compare(tag);
    @(posedge clk);
    if (!rst_n) nq = 1'b0;
    else if (aclr && mcfg[B_AEN]) nq = 1'b0;
    else if (sclr && mcfg[B_SEN]) nq = 1'b0;
    else if (ld && mcfg[B_LEN]) nq = lv;
    else if (mcfg[B_MODE] && mcfg[B_SRC]) nq = chin;
    else nq = m_comb();
    mq = nq;
    if (!rst_n) mcfg = '0;
    else if (cfg_we) mcfg = cfg_data;
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [CW-1:0] w);
    cfg_we = 1'b1; cfg_data = w;
    cyc("R1");
    cfg_we = 1'b0;
  endtask

  logic [15:0] m_xor, m_and, m_mux, m_fa;

  initial begin
    for (int i = 0; i < 16; i++) begin
      logic [3:0] v;
      v = 4'(i);
      m_xor[i] = ^v;
      m_and[i] = &v;
      m_mux[i] = v[3] ? v[2] : v[1];
    end
    for (int i = 0; i < 8; i++) begin
      logic [2:0] v;
      v = 3'(i);
      m_fa[i]     = ^v;
      m_fa[8 + i] = (int'(v[0]) + int'(v[1]) + int'(v[2])) >= 2;
    end

    @(negedge clk);
    cyc("R1");
    rst_n = 1'b1;
    cyc("R1");

    // Normal mode: three functions, all 16 inputs, carry_in toggling (R2)
    set_cfg(mk(m_xor, 0, 0, 0, 0, 0, 0));
    for (int i = 0; i < 16; i++) begin lin = 4'(i); cin = i[0]; cyc("R2"); end
    set_cfg(mk(m_and, 0, 0, 0, 0, 0, 0));
    for (int i = 0; i < 16; i++) begin lin = 4'(i); cin = ~i[1]; cyc("R2"); end
    set_cfg(mk(m_mux, 0, 0, 0, 0, 0, 0));
    for (int i = 0; i < 16; i++) begin lin = 4'(i); cin = i[2]; cyc("R2"); end

    // Arithmetic full adder, upper inputs varied to show they are ignored (R3)
    set_cfg(mk(m_fa, 1, 0, 0, 0, 0, 0));
    for (int i = 0; i < 32; i++) begin
      lin = {i[4], i[3], i[1], i[0]}; cin = i[2]; cyc("R3");
    end

    // Registered output in normal mode (R7, R8)
    set_cfg(mk(m_xor, 0, 1, 0, 0, 0, 0));
    for (int i = 0; i < 16; i++) begin lin = 4'(15 - i); cyc("R8"); end

    // Arithmetic mode, register fed from chain (R7)
    set_cfg(mk(m_fa, 1, 1, 1, 0, 0, 0));
    for (int i = 0; i < 16; i++) begin
      chin = i[0] ^ i[2]; lin = 4'(i); cin = i[3]; cyc("R7");
    end
    chin = 0;

    // Directed controls with enables set
    set_cfg(mk(m_and, 0, 1, 0, 1, 1, 1));
    ld = 1; lv = 1; lin = 0; cyc("R6");
    ld = 0; aclr = 1; cyc("R4");
    aclr = 0; ld = 1; lv = 1; cyc("R6");
    ld = 0; sclr = 1; lin = 4'hF; cyc("R5");
    sclr = 0; cyc("R7");
    sclr = 1; ld = 1; lv = 1; cyc("R9");
    sclr = 0; ld = 1; lv = 1; lin = 0; cyc("R9");
    ld = 0; lin = 4'hF;

    // Controls with enables clear are ignored (R4, R5, R6)
    set_cfg(mk(m_and, 0, 1, 0, 0, 0, 0));
    cyc("R7");
    aclr = 1; sclr = 1; ld = 1; lv = 0; cyc("R4 R5 R6");
    cyc("R4 R5 R6");
    aclr = 0; sclr = 0; ld = 0;

    // Pseudo-random mixes per enable combination (R9)
    for (int e = 0; e < 8; e++) begin
      set_cfg(mk((e % 2 == 0) ? m_fa : m_mux, e[0], e[1], e[2] ^ e[0], e[0] | e[1], e[1] | e[2], 1'b1));
      for (int n = 0; n < 120; n++) begin
        int r;
        r = int'($urandom_range(0, 1023));
        lin = 4'(r); cin = r[4]; chin = r[5];
        aclr = (r[9:7] == 3'b111); sclr = (r[9:7] == 3'b011); ld = r[6]; lv = r[8];
        cyc("R9");
      end
    end
    aclr = 0; sclr = 0; ld = 0;
    cyc("R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule